// File: doc/BRIEF.md
# External Bus Release Arbiter

This block hands the memory bus to an external master and takes it back. The master asks for the bus by pulling an active-low request line. The block waits until the internal CPU or DMA cycle in flight has finished. It then drives the strobe pins high for a fixed number of clocks, turns off its address, data and strobe drivers, and pulls the active-low acknowledge line low.

While the bus is with the external master, a DRAM refresh request can arrive. The block raises acknowledge to tell the master that refresh is needed. It does not take the bus back until the master releases its request. When that happens, the block waits a settle window, drives the pins again and grants the refresh. Internal cycles resume only after the refresh completes.

The release or refresh choice is made once per clock, and acknowledge comes straight from a flop. Because of this, a refresh that arrives at the moment of release leaves acknowledge high with no spike.

Top module: `bus_release_arb`

## Requirements
- R1: After reset the block owns the bus. All pin enables (`*_oe_o`, 1 = drive) are 1, `ack_no` is 1, `ref_gnt_o` is 0 and `int_en_o` is 1.
- R2: A low request is acted on only after `cyc_busy_i` is low. With SYNC_STAGES request synchronizer flops, `ack_no` falls max(SYNC_STAGES+2, B+1)+STRB_CYC clocks after the request falls, where B is the number of clocks that `cyc_busy_i` stays high after that edge.
- R3: Before tri-stating, `strb_high_o` is 1 for exactly STRB_CYC clocks while the address and data enables are still 1.
- R4: Whenever `ack_no` is 0, all three pin enables are 0.
- R5: A refresh request while the bus is released drives `ack_no` to 1 on the next clock. The pins stay tri-stated for as long as the request stays low.
- R6: After the request returns high, the pins are enabled SYNC_STAGES+1+REACQ_CYC clocks later. If a refresh is pending, `ref_gnt_o` is 1 and `int_en_o` is 0 at that point; otherwise `int_en_o` is 1 and `ref_gnt_o` is 0.
- R7: The pins are re-enabled only after the synchronized request has been high for REACQ_CYC clocks in a row. A request that goes high and then low again within that window keeps the bus released and brings `ack_no` back low.
- R8: A refresh request that arrives during the strobe-high phase still completes the release, and `ack_no` never goes low during that release.
- R9: A pending refresh survives repeated refresh requests and any length of release, and it is served exactly once. After `ref_done_i`, `ref_gnt_o` stays 0 and `int_en_o` stays 1.
- R10: With no request, a pending refresh clears `int_en_o` on the next clock. `ref_gnt_o` rises one clock after `cyc_busy_i` is seen low.
- R11: A request withdrawn before the current cycle completes returns the block to internal ownership. Neither `ack_no` nor any pin enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| breq_ni | input | 1 | External bus request, active low, asynchronous |
| cyc_busy_i | input | 1 | Internal CPU/DMA bus cycle in progress |
| ref_req_i | input | 1 | Refresh request pulse from the refresh timer |
| ref_done_i | input | 1 | Refresh cycle completed |
| ack_no | output | 1 | Bus acknowledge, active low, registered |
| addr_oe_o | output | 1 | Address pin driver enable |
| data_oe_o | output | 1 | Data pin driver enable |
| strb_oe_o | output | 1 | Strobe pin driver enable |
| strb_high_o | output | 1 | Force strobes to their inactive high level |
| ref_gnt_o | output | 1 | Refresh grant to the DRAM controller |
| int_en_o | output | 1 | Internal CPU/DMA cycles may start |

## Verification
The assertions assume the following about the inputs:
- `cyc_busy_i` eventually drops.
- `ref_done_i` is pulsed only while `ref_gnt_o` is high.
- `ref_req_i` and `ref_done_i` are never high in the same clock.

The stimulus meets these by driving every input at the falling edge. It raises `ref_done_i` only after it has seen the grant, and it keeps the refresh pulses one clock wide and away from completion. Busy lengths are swept across both sides of the synchronizer latency. Refresh requests are placed in the released, strobe and idle phases, so that every branch of the per-clock priority decision is exercised.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef enum logic [2:0] {
    ST_OWN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_STRB  = 3'd2,
    ST_REL   = 3'd3,
    ST_REACQ = 3'd4,
    ST_REF   = 3'd5
  } bra_state_e;
endpackage

// File: rtl/bra_sync.sv
module bra_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= d_i;
      else             chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bra_refresh_pend.sv
module bra_refresh_pend
  import bra_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_req_i,
  input  logic       ref_done_i,
  input  bra_state_e state_q_i,
  output logic       pend_d_o,
  output logic       pend_q_o
);
  logic clear;

  // done only counts while the grant is out; a new request wins over clear
  assign clear    = (state_q_i == ST_REF) && ref_done_i;
  assign pend_d_o = ref_req_i | (pend_q_o & ~clear);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q_o <= 1'b0;
    else         pend_q_o <= pend_d_o;
  end

  assert_pend_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q_o) && !$past(clear)) |-> pend_q_o);
endmodule

// File: rtl/bra_ctrl.sv
module bra_ctrl
  import bra_pkg::*;
#(
  parameter int STRB_CYC  = 2,
  parameter int REACQ_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       breq_s_i,   // synchronized, active low
  input  logic       cyc_busy_i,
  input  logic       ref_done_i,
  input  logic       pend_d_i,
  input  logic       pend_q_i,
  output bra_state_e state_q_o,
  output logic       ack_no
);
  localparam int CNT_MAX = (STRB_CYC > REACQ_CYC) ? STRB_CYC : REACQ_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  bra_state_e    state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_d;

  always_comb begin
    state_d = state_q_o;
    cnt_d   = cnt_q;
    unique case (state_q_o)
      ST_OWN:  if (!breq_s_i || pend_q_i) state_d = ST_WAIT;
      ST_WAIT: if (!cyc_busy_i) begin
        // single priority point: release first, then refresh
        if (!breq_s_i) begin
          state_d = ST_STRB;
          cnt_d   = CW'(STRB_CYC - 1);
        end else if (pend_q_i) state_d = ST_REF;
        else                   state_d = ST_OWN;
      end
      ST_STRB: if (cnt_q == '0) state_d = ST_REL;
               else             cnt_d   = cnt_q - 1'b1;
      ST_REL:  if (breq_s_i) begin
        state_d = ST_REACQ;
        cnt_d   = CW'(REACQ_CYC - 1);
      end
      ST_REACQ: begin
        if (!breq_s_i)          state_d = ST_REL;
        else if (cnt_q == '0)   state_d = pend_q_i ? ST_REF : ST_OWN;
        else                    cnt_d   = cnt_q - 1'b1;
      end
      ST_REF:  if (ref_done_i) state_d = ST_OWN;
      default: state_d = ST_OWN;
    endcase
  end

  // registered from next-state and next-pending: no spike on coincidence
  assign ack_d = !(state_d == ST_REL && !pend_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q_o <= ST_OWN;
      cnt_q     <= '0;
      ack_no    <= 1'b1;
    end else begin
      state_q_o <= state_d;
      cnt_q     <= cnt_d;
      ack_no    <= ack_d;
    end
  end

  assert_release_after_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_o == ST_STRB && $past(state_q_o) == ST_WAIT) |-> $past(!cyc_busy_i));

  assert_hold_while_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q_o == ST_REL && !breq_s_i) |=> state_q_o == ST_REL);

  assert_ack_high_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q_i |-> ack_no);

  assert_refresh_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q_o) == ST_REACQ && $past(pend_q_i) &&
     state_q_o != ST_REACQ && state_q_o != ST_REL) |-> state_q_o == ST_REF);
endmodule

// File: rtl/bra_pins.sv
module bra_pins
  import bra_pkg::*;
(
  input  bra_state_e state_q_i,
  input  logic       pend_q_i,
  output logic       addr_oe_o,
  output logic       data_oe_o,
  output logic       strb_oe_o,
  output logic       strb_high_o,
  output logic       ref_gnt_o,
  output logic       int_en_o
);
  logic drive;

  assign drive       = (state_q_i == ST_OWN)  || (state_q_i == ST_WAIT) ||
                       (state_q_i == ST_STRB) || (state_q_i == ST_REF);
  assign addr_oe_o   = drive;
  assign data_oe_o   = drive;
  assign strb_oe_o   = drive;
  assign strb_high_o = (state_q_i == ST_STRB);
  assign ref_gnt_o   = (state_q_i == ST_REF);
  assign int_en_o    = (state_q_i == ST_OWN) && !pend_q_i;
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb
  import bra_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRB_CYC    = 2,
  parameter int REACQ_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic breq_ni,
  input  logic cyc_busy_i,
  input  logic ref_req_i,
  input  logic ref_done_i,
  output logic ack_no,
  output logic addr_oe_o,
  output logic data_oe_o,
  output logic strb_oe_o,
  output logic strb_high_o,
  output logic ref_gnt_o,
  output logic int_en_o
);
  bra_state_e state_q;
  logic       breq_s, pend_d, pend_q;

  bra_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(breq_ni), .q_o(breq_s)
  );

  bra_refresh_pend u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_req_i(ref_req_i),
    .ref_done_i(ref_done_i), .state_q_i(state_q),
    .pend_d_o(pend_d), .pend_q_o(pend_q)
  );

  bra_ctrl #(.STRB_CYC(STRB_CYC), .REACQ_CYC(REACQ_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .breq_s_i(breq_s),
    .cyc_busy_i(cyc_busy_i), .ref_done_i(ref_done_i),
    .pend_d_i(pend_d), .pend_q_i(pend_q),
    .state_q_o(state_q), .ack_no(ack_no)
  );

  bra_pins u_pins (
    .state_q_i(state_q), .pend_q_i(pend_q),
    .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o), .strb_oe_o(strb_oe_o),
    .strb_high_o(strb_high_o), .ref_gnt_o(ref_gnt_o), .int_en_o(int_en_o)
  );

  assert_pins_off_when_acked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> (!addr_oe_o && !data_oe_o && !strb_oe_o));

  assert_strobe_high_before_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_oe_o) |-> $past(strb_high_o));

  assert_reenable_after_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> $past(breq_s));

  assert_int_blocked_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !int_en_o);
endmodule

// File: tb/bus_release_arb_test.sv
module bus_release_arb_test;
  localparam int SYNC  = 2;
  localparam int STRB  = 3;
  localparam int REACQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic breq_n = 1'b1, busy = 1'b0, ref_req = 1'b0, ref_done = 1'b0;
  logic ack_n, addr_oe, data_oe, strb_oe, strb_high, ref_gnt, int_en;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bus_release_arb #(.SYNC_STAGES(SYNC), .STRB_CYC(STRB), .REACQ_CYC(REACQ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .breq_ni(breq_n), .cyc_busy_i(busy),
    .ref_req_i(ref_req), .ref_done_i(ref_done), .ack_no(ack_n),
    .addr_oe_o(addr_oe), .data_oe_o(data_oe), .strb_oe_o(strb_oe),
    .strb_high_o(strb_high), .ref_gnt_o(ref_gnt), .int_en_o(int_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ref();
    ref_req = 1'b1; step(1); ref_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // release with busy held for b falling edges
  task automatic do_release(input int b);
    int n = 0, shi = 0, bad = 0;
    breq_n = 1'b0; busy = 1'b1;
    while (ack_n && n < 60) begin
      if (n == b) busy = 1'b0;
      step(1); n++;
      if (strb_high) begin
        shi++;
        if (!addr_oe || !data_oe) bad++;
      end
    end
    busy = 1'b0;
    chk($sformatf("R2 release latency b=%0d", b), n,
        ((SYNC + 2 > b + 1) ? SYNC + 2 : b + 1) + STRB);
    chk("R3 strobe-high cycles", shi, STRB);
    chk("R3 addr/data driven during strobe-high", bad, 0);
    chk("R4 pins off at release", {addr_oe, data_oe, strb_oe}, 0);
  endtask

  task automatic reacquire(output int n);
    n = 0;
    breq_n = 1'b1;
    while (!addr_oe && n < 60) begin step(1); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..R11 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int n, bad;
    step(2);
    chk("R1 reset ack", ack_n, 1);
    chk("R1 reset oe", {addr_oe, data_oe, strb_oe}, 7);
    rst_n = 1'b1;
    step(2);
    chk("R1 idle gnt", ref_gnt, 0);
    chk("R1 idle int_en", int_en, 1);

    for (int b = 0; b <= 6; b++) begin
      for (int v = 0; v < 3; v++) begin
        do_release(b);
        if (v == 0) begin
          step(3);
          chk("R4 ack low while released", ack_n, 0);
          reacquire(n);
          chk("R6 reacquire latency", n, SYNC + 1 + REACQ);
          chk("R6 no refresh grant", ref_gnt, 0);
          chk("R6 internal resumes", int_en, 1);
        end else if (v == 1) begin
          pulse_ref();
          chk("R5 ack raised for refresh", ack_n, 1);
          bad = 0;
          for (int i = 0; i < 6; i++) begin
            if (i == 2) pulse_ref();
            step(1);
            if (addr_oe || strb_oe || !ack_n) bad++;
          end
          chk("R5 stays released while req low", bad, 0);
          chk("R9 pending across repeat request", ack_n, 1);
          reacquire(n);
          chk("R6 reacquire latency with refresh", n, SYNC + 1 + REACQ);
          chk("R6 refresh granted first", ref_gnt, 1);
          chk("R6 internal held during refresh", int_en, 0);
          step(2);
          ref_done = 1'b1; step(1); ref_done = 1'b0;
          bad = 0;
          for (int i = 0; i < 5; i++) begin
            if (ref_gnt || !int_en) bad++;
            step(1);
          end
          chk("R9 refresh served once", bad, 0);
        end else begin
          // request high for one clock only
          breq_n = 1'b1; step(1); breq_n = 1'b0;
          bad = 0;
          for (int i = 0; i < 10; i++) begin
            step(1);
            if (addr_oe || data_oe || strb_oe) bad++;
          end
          chk("R7 short high keeps bus released", bad, 0);
          chk("R7 ack back low", ack_n, 0);
          reacquire(n);
          chk("R7 reacquire after short high", n, SYNC + 1 + REACQ);
        end
        step(2);
      end
    end

    // R8: refresh during the strobe phase
    breq_n = 1'b0; busy = 1'b0;
    n = 0;
    while (!strb_high && n < 60) begin step(1); n++; end
    pulse_ref();
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (!ack_n) bad++;
      step(1);
    end
    chk("R8 ack never low", bad, 0);
    chk("R8 bus still released", {addr_oe, data_oe, strb_oe}, 0);
    reacquire(n);
    chk("R8 refresh granted after return", ref_gnt, 1);
    ref_done = 1'b1; step(1); ref_done = 1'b0;
    chk("R8 internal resumes", int_en, 1);

    // R10: idle refresh behind a busy cycle
    step(3);
    busy = 1'b1;
    pulse_ref();
    chk("R10 int_en cleared", int_en, 0);
    step(2);
    chk("R10 no grant while busy", ref_gnt, 0);
    busy = 1'b0;
    step(1);
    chk("R10 grant after busy drops", ref_gnt, 1);
    chk("R10 pins driven for refresh", addr_oe, 1);
    ref_done = 1'b1; step(1); ref_done = 1'b0;
    chk("R10 internal resumes", int_en, 1);

    // R11: request withdrawn while busy
    step(3);
    busy = 1'b1; breq_n = 1'b0;
    bad = 0;
    for (int i = 0; i < 14; i++) begin
      if (i == 3) breq_n = 1'b1;
      if (i == 6) busy = 1'b0;
      step(1);
      if (!ack_n || !strb_oe || !addr_oe) bad++;
    end
    chk("R11 no release after withdraw", bad, 0);
    chk("R11 internal owner again", int_en, 1);

    finish_run();
  end
endmodule